// File: doc/BRIEF.md
# Registered Four-Bit Arithmetic-Logic Unit

This block performs one of twelve arithmetic or bitwise operations on two 4-bit operands. A mode input selects between an arithmetic path and a logic path. A 2-bit select and a carry-in choose the operation within that path. Every input is captured in an input register bank, and the result is held in an output register bank. A new operation can enter on every clock cycle, and its result appears two rising edges after it was applied.

The arithmetic path conditions the second operand into one of four forms: zero, passed through, inverted, or all ones. It then adds that value to the first operand and the carry-in through a chain of full adders. With the carry-in, this gives transfer, increment, decrement, add and subtract from one adder. The logic path forms XOR, OR, AND, or the inverse of the first operand. In logic mode the carry-in has no effect and the registered carry-out is forced low.

Top module: `alu4_reg`

## Requirements
- R1: A synchronous active-high reset clears the registered result and carry-out to zero on the next rising edge, whatever the data inputs hold.
- R2: With modeLogic=0, {carryOut,result} equals opA + X + carryIn as a 5-bit sum. X is 0000 for sel=00, opB for sel=01, the bitwise inverse of opB for sel=10, and 1111 for sel=11.
- R3: With modeLogic=0, the code {sel,carryIn} selects the following. 000 is transfer A, 001 is A+1, 010 is A+B, 011 is A+B+1, 100 is A+B', 101 is A+B'+1 (A minus B), 110 is A-1, and 111 is transfer A.
- R4: With modeLogic=1, sel=00 gives opA XOR opB, sel=01 gives opA OR opB, sel=10 gives opA AND opB, and sel=11 gives NOT opA.
- R5: With modeLogic=1, carryIn has no effect on result.
- R6: With modeLogic=1, the registered carryOut is 0.
- R7: An operation applied before rising edge k appears on the outputs after rising edge k+1. After edge k alone the outputs still show the previous operation. A different operation may be applied every cycle.
- R8: For A-1 (modeLogic=0, sel=11, carryIn=0), carryOut is 1 for every opA except 0000, where the result is 1111 and carryOut is 0.
- R9: The carry ripples through all four bit positions. 1111+0001 gives result 0000 with carryOut 1, and 0111+0001 gives 1000 with carryOut 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opA | input | 4 | First operand |
| opB | input | 4 | Second operand |
| modeLogic | input | 1 | 0 selects arithmetic, 1 selects bitwise logic |
| sel | input | 2 | Operation select within the mode |
| carryIn | input | 1 | Carry into bit 0 (arithmetic only) |
| result | output | 4 | Registered result |
| carryOut | output | 1 | Registered carry out of bit 3, 0 in logic mode |

## Verification
The bench sweeps all 4096 combinations of operands, mode, select and carry-in back to back, one per cycle. This exposes a latency error: an extra or missing pipeline stage would pair every result with the wrong vector. Directed cases target the full carry ripple, where a broken chain gives 1110 or a lost carry on 1111+0001. They also cover decrement of zero, where a wrong carry polarity reports a borrow as a carry. In logic mode the bench watches for a leaking carry-in that flips the low bit, and for a stale adder carry reaching carryOut. A mid-run reset with live operands must still clear both outputs.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  // Strobes from the opcode decoder to the datapath
  typedef struct packed {
    logic bZero;    // second operand forced to zero
    logic bPass;    // second operand passed unchanged
    logic bInv;     // second operand inverted
    logic bOnes;    // second operand forced to all ones
    logic isLogic;  // result taken from bitwise unit
    logic opXor;
    logic opOr;
    logic opAnd;
    logic opNot;
    logic cinEff;   // carry fed into bit 0 of the adder
  } aluStrobes_t;
endpackage

// File: rtl/alu4_fa.sv
module alu4_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (ci & (x ^ y));
  end
endmodule

// File: rtl/alu4_ctrl.sv
module alu4_ctrl
  import alu4_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        modeLogic,
  input  logic [1:0]  sel,
  input  logic        carryIn,
  output aluStrobes_t st
);
  always_comb begin
    st = '0;
    if (!modeLogic) begin
      st.cinEff = carryIn;
      unique case (sel)
        2'b00:   st.bZero = 1'b1;
        2'b01:   st.bPass = 1'b1;
        2'b10:   st.bInv  = 1'b1;
        default: st.bOnes = 1'b1;
      endcase
    end else begin
      st.isLogic = 1'b1;
      unique case (sel)
        2'b00:   st.opXor = 1'b1;
        2'b01:   st.opOr  = 1'b1;
        2'b10:   st.opAnd = 1'b1;
        default: st.opNot = 1'b1;
      endcase
    end
  end

  // R2: exactly one operand conditioning form in arithmetic mode
  p_bsel_single_r2: assert property (@(posedge clk) disable iff (rst)
    !st.isLogic |-> ($countones({st.bZero, st.bPass, st.bInv, st.bOnes}) == 1
                     && $countones({st.opXor, st.opOr, st.opAnd, st.opNot}) == 0));

  // R5: logic mode feeds no carry and picks exactly one bitwise op
  p_logic_no_cin_r5: assert property (@(posedge clk) disable iff (rst)
    st.isLogic |-> (!st.cinEff
                    && $countones({st.opXor, st.opOr, st.opAnd, st.opNot}) == 1));
endmodule

// File: rtl/alu4_datapath.sv
module alu4_datapath
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  aluStrobes_t  st,
  output logic [W-1:0] res,
  output logic         cOut
);
  localparam int SW = W + 1;

  logic [W-1:0] bx;
  logic [W-1:0] sum;
  logic [W:0]   chain;
  logic [W-1:0] logicRes;

  // operand conditioning
  always_comb begin
    bx = ({W{st.bPass}} & bIn) | ({W{st.bInv}} & ~bIn) | {W{st.bOnes}};
  end

  assign chain[0] = st.cinEff;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_rip
      alu4_fa u_fa (
        .x (aIn[i]),
        .y (bx[i]),
        .ci(chain[i]),
        .s (sum[i]),
        .co(chain[i+1])
      );
    end
  endgenerate

  // bitwise unit
  always_comb begin
    logicRes = ({W{st.opXor}} & (aIn ^ bIn))
             | ({W{st.opOr}}  & (aIn | bIn))
             | ({W{st.opAnd}} & (aIn & bIn))
             | ({W{st.opNot}} & ~aIn);
  end

  // final select
  always_comb begin
    res  = st.isLogic ? logicRes : sum;
    cOut = st.isLogic ? 1'b0 : chain[W];
  end

  // R9: the ripple chain agrees with a plain wide sum
  p_ripple_sum_r9: assert property (@(posedge clk) disable iff (rst)
    !st.isLogic |-> ({chain[W], sum} ==
                     (SW'(aIn) + SW'(bx) + SW'(st.cinEff))));
endmodule

// File: rtl/alu4_reg.sv
module alu4_reg
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         modeLogic,
  input  logic [1:0]   sel,
  input  logic         carryIn,
  output logic [W-1:0] result,
  output logic         carryOut
);
  logic [W-1:0] aR, bR;
  logic         mR, cR;
  logic [1:0]   sR;
  aluStrobes_t  strobes;
  logic [W-1:0] dpRes;
  logic         dpCarry;

  // input bank
  always_ff @(posedge clk) begin
    if (rst) begin
      aR <= '0; bR <= '0; mR <= 1'b0; sR <= '0; cR <= 1'b0;
    end else begin
      aR <= opA; bR <= opB; mR <= modeLogic; sR <= sel; cR <= carryIn;
    end
  end

  alu4_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .modeLogic(mR),
    .sel      (sR),
    .carryIn  (cR),
    .st       (strobes)
  );

  alu4_datapath #(.W(W)) u_dp (
    .clk (clk),
    .rst (rst),
    .aIn (aR),
    .bIn (bR),
    .st  (strobes),
    .res (dpRes),
    .cOut(dpCarry)
  );

  // output bank
  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      carryOut <= 1'b0;
    end else begin
      result   <= dpRes;
      carryOut <= dpCarry;
    end
  end

  // R1: reset clears the output bank
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (result == '0 && !carryOut));

  // R6: a logic op in the input bank never yields a carry
  p_logic_carry_zero_r6: assert property (@(posedge clk) disable iff (rst)
    mR |=> !carryOut);

  // R7: input bank follows the ports one edge later
  p_input_capture_r7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (aR == $past(opA) && bR == $past(opB) && mR == $past(modeLogic)));
endmodule

// File: tb/tb_alu4_reg.sv
module tb_alu4_reg;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] opA, opB;
  logic       modeLogic;
  logic [1:0] sel;
  logic       carryIn;
  logic [3:0] result;
  logic       carryOut;

  int nTests = 0;
  int nFail  = 0;

  always #4 clk = ~clk;  // 125 MHz

  alu4_reg dut (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .modeLogic(modeLogic),
    .sel(sel), .carryIn(carryIn), .result(result), .carryOut(carryOut)
  );

  function automatic logic [4:0] model(input logic [3:0] a, input logic [3:0] b,
                                       input logic m, input logic [1:0] s,
                                       input logic ci);
    logic [3:0] x;
    if (m) begin
      case (s)
        2'd0: x = a ^ b;
        2'd1: x = a | b;
        2'd2: x = a & b;
        default: x = ~a;
      endcase
      return {1'b0, x};
    end
    case (s)
      2'd0: x = 4'h0;
      2'd1: x = b;
      2'd2: x = ~b;
      default: x = 4'hF;
    endcase
    return {1'b0, a} + {1'b0, x} + {4'h0, ci};
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    nTests++;
    if ({carryOut, result} !== exp) begin
      nFail++;
      $display("FAIL %s: got carry=%0b result=%h, expected carry=%0b result=%h",
               req, carryOut, result, exp[4], exp[3:0]);
    end
  endtask

  task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic m,
                       input logic [1:0] s, input logic ci);
    opA = a; opB = b; modeLogic = m; sel = s; carryIn = ci;
  endtask

  task automatic runOp(input logic [3:0] a, input logic [3:0] b, input logic m,
                       input logic [1:0] s, input logic ci, input string req,
                       input logic [4:0] exp);
    @(negedge clk);
    drive(a, b, m, s, ci);
    @(negedge clk);
    @(negedge clk);
    check(req, exp);
  endtask

  logic [4:0] expV [0:4095];
  string      tagV [0:4095];

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R7: watchdog expired, got no end, expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(4'h0, 4'h0, 1'b0, 2'd0, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 reset state", 5'h00);
    rst = 1'b0;

    // R3 named operations, A=1001 B=0101
    runOp(4'h9, 4'h5, 1'b0, 2'b00, 1'b0, "R3 transfer A", 5'h09);
    runOp(4'h9, 4'h5, 1'b0, 2'b00, 1'b1, "R3 A+1",        5'h0A);
    runOp(4'h9, 4'h5, 1'b0, 2'b01, 1'b0, "R3 A+B",        5'h0E);
    runOp(4'h9, 4'h5, 1'b0, 2'b01, 1'b1, "R3 A+B+1",      5'h0F);
    runOp(4'h9, 4'h5, 1'b0, 2'b10, 1'b0, "R3 A+B'",       5'h13);
    runOp(4'h9, 4'h5, 1'b0, 2'b10, 1'b1, "R3 A-B",        5'h14);
    runOp(4'h9, 4'h5, 1'b0, 2'b11, 1'b0, "R3 A-1",        5'h18);
    runOp(4'h9, 4'h5, 1'b0, 2'b11, 1'b1, "R3 transfer A", 5'h19);

    // R8 decrement carry
    runOp(4'h0, 4'h3, 1'b0, 2'b11, 1'b0, "R8 0-1",  5'h0F);
    runOp(4'h1, 4'h3, 1'b0, 2'b11, 1'b0, "R8 1-1",  5'h10);
    runOp(4'h8, 4'h3, 1'b0, 2'b11, 1'b0, "R8 8-1",  5'h17);

    // R9 full ripple
    runOp(4'hF, 4'h1, 1'b0, 2'b01, 1'b0, "R9 F+1",   5'h10);
    runOp(4'h7, 4'h1, 1'b0, 2'b01, 1'b0, "R9 7+1",   5'h08);
    runOp(4'hF, 4'hF, 1'b0, 2'b01, 1'b1, "R9 F+F+1", 5'h1F);

    // R5 / R6 logic with carry-in set
    runOp(4'hF, 4'h4, 1'b1, 2'b00, 1'b1, "R5 xor cin=1", 5'h0B);
    runOp(4'h6, 4'hA, 1'b1, 2'b11, 1'b1, "R6 not cin=1", 5'h09);

    // R7 latency: previous op still visible after one edge
    @(negedge clk);
    drive(4'h3, 4'h4, 1'b0, 2'b01, 1'b0);
    @(negedge clk);
    check("R7 one edge, old value", 5'h09);
    @(negedge clk);
    check("R7 two edges, new value", 5'h07);

    // R2 R4 R5 R6 R7: exhaustive back-to-back sweep
    for (int k = 0; k < 4096 + 2; k++) begin
      @(negedge clk);
      if (k >= 2) check(tagV[k-2], expV[k-2]);
      if (k < 4096) begin
        logic [11:0] v;
        v = 12'(k);
        drive(v[3:0], v[7:4], v[11], v[9:8], v[10]);
        expV[k] = model(v[3:0], v[7:4], v[11], v[9:8], v[10]);
        tagV[k] = v[11] ? (v[10] ? "R5 R6 sweep" : "R4 R6 sweep") : "R2 R7 sweep";
      end
    end

    // R1 mid-run reset with live operands
    @(negedge clk);
    drive(4'hF, 4'hF, 1'b0, 2'b01, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", 5'h00);
    rst = 1'b0;

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule